// File: doc/BRIEF.md
# Front Panel Mirror Register Controller

This block is the bus-slave register file of a 16-bit peripheral that mirrors a remote operator panel of switches and lamps. A word-addressed host port reaches a small set of fixed control registers, followed by one word per switch group and one word per lamp group. On the switch side, the block takes a snapshot of the live switch words on a programmable millisecond period. When a word has changed since the last snapshot, it raises an event and records the bus address of the changed word. On the lamp side, lamp words written by the host are held back. They are copied to the panel-facing outputs only when the lamp timer fires, and each such copy raises its own event.

A free-running prescaler turns the system clock into a 1 ms tick. That tick drives two independent period counters, one for polling and one for updating. Each event flag has an enable bit, and together they produce an interrupt request. Reading a status register clears the event it shows. A panel-connected input feeds the error bit of both status registers. Polling stops while the panel is absent. The lamp timer and its interrupt keep running, so that side can also serve as a general programmable interval timer.

Top module: `panel_mirror_regs`

## Requirements
- R1: After reset, both status registers read 0 apart from the error bit, the poll period reads 50, the update period reads 10, the changed-address and config words read 0, and every lamp output word and the test-mode output are 0.
- R2: The status registers sit at byte offsets 0 (switch side) and 2 (lamp side). In both, bit 15 reads 1 when the panel is not connected, bit 7 is the event flag and bit 6 is the read/write interrupt enable. The lamp status register also holds a read/write test mode in bits 1:0 (0 normal, 1 lamp test, 2 full test, 3 powerless), which is driven on `panel_test`.
- R3: The period registers sit at offsets 4 (poll) and 6 (update) and use bits 9:0. A nonzero period P produces one timer event every P*CLK_PER_MS clock cycles. Writing a period register restarts that counter at the new value.
- R4: A period of 0 stops that side: no poll, no lamp update and no event.
- R5: At a poll tick with the panel connected, every switch word is captured. If any word differs from its previous capture, the switch event is set and offset 8 latches BASE+12+2*i, where i is the lowest-indexed word that changed. The switch word at offset 12+2*i reads back the captured value.
- R6: A poll that finds no changed word sets no event.
- R7: A read of a status register clears only that register's event flag. An event arriving in the same cycle as the read wins over the clear.
- R8: Each interrupt request is high while its event flag and its enable bit are both set. When both are pending, only the switch request is driven, and the lamp request follows once the switch request drops.
- R9: Host writes to lamp words (offset 12+2*NS+2*j) appear on `lamp_out` only at the next update tick, and every update tick sets the lamp event.
- R10: With the panel disconnected, the lamp timer, lamp event and lamp interrupt keep running, while switch polling is suspended.
- R11: Switch words ignore host writes. The config word at offset 10 is freely readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (triggers read-to-clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| panel_ok | input | 1 | Panel connection present |
| sw_in | input | NS x 16 | Live switch words from the panel side |
| lamp_out | output | NL x 16 | Lamp words last pushed to the panel |
| panel_test | output | 2 | Selected test mode |
| irq_in | output | 1 | Switch-change interrupt request |
| irq_out | output | 1 | Lamp-update interrupt request |

## Verification
The switch side is driven with random sets of changed words, and with directed cases for no change, a change in only the highest word and a change in every word. These cases separate correct lowest-index selection from first-found or last-found logic, and show that a quiet poll raises nothing. The lamp side is timed edge to edge at a short period, which exposes off-by-one errors in the reload. The lamp output is also watched before and after a tick, which exposes writes that leak straight through. Running with both events pending, and again with the panel unplugged, checks the interrupt ordering, that a read clears only its own flag, and that the lamp timer runs on while polling stops.

// File: rtl/panel_mirror_pkg.sv
package panel_mirror_pkg;
    localparam int WIDX_ICSR   = 0;
    localparam int WIDX_OCSR   = 1;
    localparam int WIDX_IPER   = 2;
    localparam int WIDX_OPER   = 3;
    localparam int WIDX_CHG    = 4;
    localparam int WIDX_CFG    = 5;
    localparam int WIDX_MAP0   = 6;
    localparam int SW_BYTE0    = 12;
    localparam int PER_W       = 10;
    localparam int BIT_ERR     = 15;
    localparam int BIT_EVT     = 7;
    localparam int BIT_IE      = 6;

    typedef enum logic [1:0] {
        TM_NORMAL    = 2'd0,
        TM_LAMP      = 2'd1,
        TM_FULL      = 2'd2,
        TM_POWERLESS = 2'd3
    } test_mode_e;
endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
    parameter int CLK_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ms_tick
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

    logic [PW-1:0] cnt_q, cnt_d;

    always_comb begin
        ms_tick = (cnt_q == PW'(CLK_PER_MS - 1));
        cnt_d   = ms_tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
    parameter int          PER_W   = 10,
    parameter logic [9:0]  RST_PER = 10'd50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [PER_W-1:0] period,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (ms_tick && period != '0) begin
            if (cnt_q <= PER_W'(1)) begin
                tick  = 1'b1;
                cnt_d = period;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= PER_W'(RST_PER);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/panel_mirror_regs.sv
module panel_mirror_regs
    import panel_mirror_pkg::*;
#(
    parameter int          CLK_PER_MS = 1000,
    parameter int          NS         = 4,
    parameter int          NL         = 4,
    parameter int          ADDR_W     = 6,
    parameter logic [15:0] BASE       = 16'o160200,
    parameter logic [9:0]  IPER_RST   = 10'd50,
    parameter logic [9:0]  OPER_RST   = 10'd10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              reg_rdata,
    input  logic                     panel_ok,
    input  logic [NS-1:0][15:0]      sw_in,
    output logic [NL-1:0][15:0]      lamp_out,
    output logic [1:0]               panel_test,
    output logic                     irq_in,
    output logic                     irq_out
);
    localparam int WIDX_LAMP0 = WIDX_MAP0 + NS;

    typedef struct packed {
        logic                 iie;
        logic                 ievt;
        logic                 oie;
        logic                 oevt;
        test_mode_e           tmode;
        logic [15:0]          chg;
        logic [15:0]          cfg;
        logic [PER_W-1:0]     iper;
        logic [PER_W-1:0]     oper;
        logic [NS-1:0][15:0]  sw;
        logic [NL-1:0][15:0]  lamp;
        logic [NL-1:0][15:0]  shown;
    } regs_t;

    regs_t r_q, r_d;

    logic              ms_tick;
    logic              in_tick, out_tick;
    logic              even;
    int                widx;
    logic              iper_load, oper_load;
    logic              poll_now;
    logic              any_chg;
    int                first_chg;

    assign even      = ~reg_addr[0];
    assign widx      = int'(reg_addr[ADDR_W-1:1]);
    assign iper_load = reg_wr && even && widx == WIDX_IPER;
    assign oper_load = reg_wr && even && widx == WIDX_OPER;

    ms_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick)
    );

    period_timer #(.PER_W(PER_W), .RST_PER(IPER_RST)) u_in_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .period   (r_q.iper),
        .load     (iper_load),
        .load_val (reg_wdata[PER_W-1:0]),
        .tick     (in_tick)
    );

    period_timer #(.PER_W(PER_W), .RST_PER(OPER_RST)) u_out_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .period   (r_q.oper),
        .load     (oper_load),
        .load_val (reg_wdata[PER_W-1:0]),
        .tick     (out_tick)
    );

    // Lowest-indexed switch word that differs from its last capture
    always_comb begin
        any_chg   = 1'b0;
        first_chg = 0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (sw_in[i] != r_q.sw[i]) begin
                any_chg   = 1'b1;
                first_chg = i;
            end
        end
    end

    assign poll_now = in_tick && panel_ok;

    always_comb begin
        r_d = r_q;

        // host writes
        if (reg_wr && even) begin
            case (widx)
                WIDX_ICSR: r_d.iie = reg_wdata[BIT_IE];
                WIDX_OCSR: begin
                    r_d.oie   = reg_wdata[BIT_IE];
                    r_d.tmode = test_mode_e'(reg_wdata[1:0]);
                end
                WIDX_IPER: r_d.iper = reg_wdata[PER_W-1:0];
                WIDX_OPER: r_d.oper = reg_wdata[PER_W-1:0];
                WIDX_CFG:  r_d.cfg  = reg_wdata;
                default: ;
            endcase
            for (int j = 0; j < NL; j++) begin
                if (widx == WIDX_LAMP0 + j) r_d.lamp[j] = reg_wdata;
            end
        end

        // read-to-clear, before the sets so a new event wins
        if (reg_rd && even && widx == WIDX_ICSR) r_d.ievt = 1'b0;
        if (reg_rd && even && widx == WIDX_OCSR) r_d.oevt = 1'b0;

        // switch poll
        if (poll_now) begin
            r_d.sw = sw_in;
            if (any_chg) begin
                r_d.ievt = 1'b1;
                r_d.chg  = BASE + 16'(SW_BYTE0 + 2 * first_chg);
            end
        end

        // lamp update
        if (out_tick) begin
            r_d.shown = r_q.lamp;
            r_d.oevt  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.iper  <= IPER_RST;
            r_q.oper  <= OPER_RST;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (even) begin
            case (widx)
                WIDX_ICSR: begin
                    reg_rdata[BIT_ERR] = ~panel_ok;
                    reg_rdata[BIT_EVT] = r_q.ievt;
                    reg_rdata[BIT_IE]  = r_q.iie;
                end
                WIDX_OCSR: begin
                    reg_rdata[BIT_ERR] = ~panel_ok;
                    reg_rdata[BIT_EVT] = r_q.oevt;
                    reg_rdata[BIT_IE]  = r_q.oie;
                    reg_rdata[1:0]     = r_q.tmode;
                end
                WIDX_IPER: reg_rdata[PER_W-1:0] = r_q.iper;
                WIDX_OPER: reg_rdata[PER_W-1:0] = r_q.oper;
                WIDX_CHG:  reg_rdata = r_q.chg;
                WIDX_CFG:  reg_rdata = r_q.cfg;
                default: ;
            endcase
            for (int i = 0; i < NS; i++) begin
                if (widx == WIDX_MAP0 + i) reg_rdata = r_q.sw[i];
            end
            for (int j = 0; j < NL; j++) begin
                if (widx == WIDX_LAMP0 + j) reg_rdata = r_q.lamp[j];
            end
        end
    end

    assign lamp_out   = r_q.shown;
    assign panel_test = r_q.tmode;
    assign irq_in     = r_q.ievt & r_q.iie;
    assign irq_out    = r_q.oevt & r_q.oie & ~irq_in;
endmodule

// File: rtl/panel_mirror_chk.sv
module panel_mirror_chk #(
    parameter int NL     = 4,
    parameter int ADDR_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                panel_ok,
    input logic                in_tick,
    input logic                out_tick,
    input logic [9:0]          oper,
    input logic                ievt,
    input logic                oevt,
    input logic                irq_in,
    input logic                irq_out,
    input logic [NL-1:0][15:0] lamp_out
);
    // R8
    irq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_in && irq_out));

    // R9
    lamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |=> $stable(lamp_out));

    // R9
    oevt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |=> oevt);

    // R7
    ievt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == '0 && !(in_tick && panel_ok)) |=> !ievt);

    // R4
    oper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oper == 10'd0) |-> !out_tick);

    // R10
    no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!panel_ok && !ievt && !(reg_rd && reg_addr == '0)) |=> !ievt);
endmodule

bind panel_mirror_regs panel_mirror_chk #(.NL(NL), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .panel_ok (panel_ok),
    .in_tick  (in_tick),
    .out_tick (out_tick),
    .oper     (r_q.oper),
    .ievt     (r_q.ievt),
    .oevt     (r_q.oevt),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .lamp_out (lamp_out)
);

// File: tb/panel_mirror_regs_tb.sv
module panel_mirror_regs_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          CPM        = 4;
    localparam int          NS         = 4;
    localparam int          NL         = 4;
    localparam int          AW         = 6;
    localparam logic [15:0] BASE       = 16'o160200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              panel_ok = 1'b1;
    logic [NS-1:0][15:0] sw_in = '0;
    logic [NL-1:0][15:0] lamp_out;
    logic [1:0]        panel_test;
    logic              irq_in, irq_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    panel_mirror_regs #(
        .CLK_PER_MS(CPM), .NS(NS), .NL(NL), .ADDR_W(AW), .BASE(BASE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .panel_ok(panel_ok), .sw_in(sw_in), .lamp_out(lamp_out),
        .panel_test(panel_test), .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [AW-1:0] sw_off(int i);
        return AW'(12 + 2 * i);
    endfunction
    function automatic logic [AW-1:0] lamp_off(int j);
        return AW'(12 + 2 * NS + 2 * j);
    endfunction
    function automatic int lowest(logic [NS-1:0] m);
        for (int i = 0; i < NS; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(bit out_side, int lim, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if ((out_side ? irq_out : irq_in) === 1'b1) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        bit seen;
        int t1, t2;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(AW'(0), rd);  check("R1 icsr", rd, 16'h0000);
        bus_rd(AW'(2), rd);  check("R1 ocsr", rd, 16'h0000);
        bus_rd(AW'(4), rd);  check("R1 iper", rd, 16'd50);
        bus_rd(AW'(6), rd);  check("R1 oper", rd, 16'd10);
        bus_rd(AW'(8), rd);  check("R1 chg",  rd, 16'h0000);
        bus_rd(AW'(10), rd); check("R1 cfg",  rd, 16'h0000);
        check("R1 lamp_out", lamp_out, '0);
        check("R1 panel_test", panel_test, 2'd0);

        // R11 config r/w, switch words read-only
        bus_wr(AW'(10), 16'hA5C3);
        bus_rd(AW'(10), rd); check("R11 cfg", rd, 16'hA5C3);
        bus_wr(sw_off(0), 16'hFFFF);
        bus_rd(sw_off(0), rd); check("R11 sw read-only", rd, 16'h0000);

        // R2 test mode field
        bus_wr(AW'(2), 16'h0002);
        bus_rd(AW'(2), rd); check("R2 ocsr tmode", rd & 16'hFF7F, 16'h0002);
        check("R2 panel_test", panel_test, 2'd2);

        // R3 update interval, R9 lamp hold
        bus_wr(AW'(2), 16'h0040);
        bus_wr(AW'(6), 16'd3);
        bus_rd(AW'(2), rd);
        wait_irq(1'b1, 200, seen);
        t1 = cyc;
        check("R3 first update irq", seen, 1'b1);
        bus_rd(AW'(2), rd); check("R7 ocsr event seen", rd, 16'h00C0);
        bus_rd(AW'(2), rd); check("R7 ocsr cleared", rd, 16'h0040);
        bus_wr(lamp_off(0), 16'h1234);
        check("R9 lamp held", lamp_out[0], 16'h0000);
        wait_irq(1'b1, 200, seen);
        t2 = cyc;
        check("R3 interval", t2 - t1, 3 * CPM);
        check("R9 lamp shown", lamp_out[0], 16'h1234);

        // R4 period zero
        bus_wr(AW'(6), 16'd0);
        bus_rd(AW'(2), rd);
        bus_wr(lamp_off(1), 16'h5555);
        repeat (100) @(negedge clk);
        check("R4 no irq", irq_out, 1'b0);
        check("R4 lamp frozen", lamp_out[1], 16'h0000);

        // R5/R6 random switch changes
        bus_wr(AW'(4), 16'd2);
        bus_wr(AW'(0), 16'h0040);
        for (int r = 0; r < 16; r++) begin
            logic [NS-1:0] m;
            int lo;
            m = NS'($urandom);
            if (r == 3) m = '0;
            if (r == 5) m = 4'b1000;
            if (r == 6) m = 4'b1111;
            if (r != 3 && m == '0) m = 4'b0100;
            @(negedge clk);
            for (int i = 0; i < NS; i++)
                if (m[i]) sw_in[i] = sw_in[i] ^ (16'($urandom) | 16'h0001);
            if (m == '0) begin
                repeat (30) @(negedge clk);
                check("R6 quiet poll irq", irq_in, 1'b0);
                bus_rd(AW'(0), rd); check("R6 quiet poll csr", rd, 16'h0040);
            end else begin
                lo = lowest(m);
                wait_irq(1'b0, 40, seen);
                check("R5 change irq", seen, 1'b1);
                bus_rd(AW'(8), rd); check("R5 changed addr", rd, BASE + 16'(12 + 2 * lo));
                bus_rd(sw_off(lo), rd); check("R5 snapshot", rd, sw_in[lo]);
                bus_rd(AW'(0), rd); check("R7 icsr event", rd, 16'h00C0);
                check("R7 icsr irq cleared", irq_in, 1'b0);
            end
        end

        // R8 priority with both pending
        bus_wr(AW'(6), 16'd1);
        repeat (10) @(negedge clk);
        @(negedge clk);
        sw_in[1] = sw_in[1] ^ 16'h0100;
        wait_irq(1'b0, 40, seen);
        check("R8 irq_in raised", seen, 1'b1);
        check("R8 irq_out masked", irq_out, 1'b0);
        bus_rd(AW'(0), rd);
        check("R8 irq_in dropped", irq_in, 1'b0);
        check("R8 irq_out follows", irq_out, 1'b1);

        // R10 disconnected panel
        panel_ok = 1'b0;
        bus_rd(AW'(0), rd); check("R10 icsr err", rd, 16'h8040);
        bus_rd(AW'(2), rd); check("R10 ocsr err", rd & 16'h8040, 16'h8040);
        wait_irq(1'b1, 40, seen);
        check("R10 timer runs", seen, 1'b1);
        @(negedge clk);
        sw_in[2] = sw_in[2] ^ 16'h0F0F;
        repeat (40) @(negedge clk);
        check("R10 poll suspended", irq_in, 1'b0);
        panel_ok = 1'b1;
        wait_irq(1'b0, 40, seen);
        check("R10 poll resumes", seen, 1'b1);
        bus_rd(AW'(8), rd); check("R10 changed addr", rd, BASE + 16'(12 + 4));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule